// File: doc/BRIEF.md
# Line Status Event Latch with Gated Interrupt

This block collects the live status signals of one line-interface port and turns them into sticky event bits in a 16-bit register. Different bits use different capture rules. Seven status inputs record a transition in either direction. The clock-loss input is captured as a level. An 8-bit receive gain word records any change of its value. Two jitter-buffer bits capture a full or an empty condition, and both also capture a data-loss pulse.

Software reads the register at a fixed per-port address and clears bits by writing ones. The block raises a registered interrupt when an enabled event bit is set. It requires three enables at once: a per-bit mask, a port enable and a global enable for this port.

Top module: `line_status_latch`

## Requirements
- R1: While reset is asserted, and after it is released with no events, the register reads 0x0000 and irq_o is low.
- R2: `chg_stat_i[k]` sets register bit k for k = 0..4, and sets bit 9 for k = 5 and bit 10 for k = 6. The bit is set on the clock edge that samples a value different from the value sampled on the previous edge, in either direction.
- R3: Bit 8 is set on every edge that samples `clk_loss_i` high. A clear written while the input is still high leaves the bit set.
- R4: Bit 5 is set on any edge where `gain_i` differs from its value at the previous edge.
- R5: Bit 12 is set when `buf_full_i` or `buf_slip_i` is high. Bit 11 is set when `buf_empty_i` or `buf_slip_i` is high.
- R6: A write to the register address clears each bit whose write-data bit is 1. Bits whose write-data bit is 0 are kept. If a set condition occurs on the same edge as a clear, the bit ends up set. Set bits stay set until cleared.
- R7: Bits 15:13 and 7:6 always read 0, even after a write of all ones.
- R8: The register address is PORT_IDX*0x80 + 0x2A. At any other address the read data is 0 and writes change nothing.
- R9: irq_o goes high one edge after (register AND bit_en_i) is nonzero while port_en_i and glob_en_i are both high. Otherwise it is low.
- R10: The first edge after reset release only loads the reference copies of `chg_stat_i` and `gain_i`. Input values held through reset set no bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chg_stat_i | input | 7 | Live status inputs captured on change |
| clk_loss_i | input | 1 | Live master-clock loss, level captured |
| gain_i | input | 8 | Receive gain level word |
| buf_full_i | input | 1 | Jitter buffer full |
| buf_empty_i | input | 1 | Jitter buffer empty |
| buf_slip_i | input | 1 | Data lost by buffer over- or underflow |
| bit_en_i | input | 16 | Per-bit interrupt enables |
| port_en_i | input | 1 | Port-level interrupt enable |
| glob_en_i | input | 1 | Global enable for this port |
| reg_addr_i | input | 12 | Register access address |
| reg_wr_i | input | 1 | Write strobe (write-one-to-clear) |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data, combinational on address |
| irq_o | output | 1 | Registered interrupt |

## Verification
The bench builds the block with PORT_IDX = 5, so the register sits at 0x2AA. This makes the address arithmetic visible, and random addresses then often miss the register. The default 12-bit address and 8-bit gain widths are kept, so all of the gain word and both sides of the address decode are covered. Random toggles, clears and enable changes are mixed with directed cases: set and clear on the same edge, clock loss held high through a clear, and inputs held through reset.

// File: rtl/lsl_pkg.sv
package lsl_pkg;
  localparam int unsigned REG_W     = 16;
  localparam int unsigned N_CHG     = 7;
  localparam int unsigned POS_FULL  = 12;
  localparam int unsigned POS_EMPTY = 11;
  localparam int unsigned POS_CLK   = 8;
  localparam int unsigned POS_GAIN  = 5;
  localparam logic [REG_W-1:0] USED_MASK = 16'h1F3F;
  // bits fed by change detection (suppressed before arming)
  localparam logic [REG_W-1:0] CHG_MASK  = 16'h063F;

  // change-input index to register bit: 0..4 direct, 5->9, 6->10
  function automatic int unsigned chg_pos(input int unsigned idx);
    return (idx < 5) ? idx : idx + 4;
  endfunction
endpackage

// File: rtl/lsl_chg_det.sv
module lsl_chg_det #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         arm_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] chg_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= d_i;
  end

  assign chg_o = arm_i ? (d_i ^ prev_q) : '0;
endmodule

// File: rtl/lsl_event_map.sv
module lsl_event_map
  import lsl_pkg::*;
(
  input  logic [N_CHG-1:0] chg_ev_i,
  input  logic             gain_ev_i,
  input  logic             clk_loss_i,
  input  logic             full_i,
  input  logic             empty_i,
  input  logic             slip_i,
  output logic [REG_W-1:0] ev_o
);
  always_comb begin
    ev_o = '0;
    for (int unsigned i = 0; i < N_CHG; i++) ev_o[chg_pos(i)] = chg_ev_i[i];
    ev_o[POS_GAIN]  = gain_ev_i;
    ev_o[POS_CLK]   = clk_loss_i;
    ev_o[POS_FULL]  = full_i | slip_i;
    ev_o[POS_EMPTY] = empty_i | slip_i;
  end
endmodule

// File: rtl/lsl_sticky.sv
module lsl_sticky
  import lsl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] set_i,
  input  logic [REG_W-1:0] clr_i,
  output logic [REG_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= ((q_o & ~clr_i) | set_i) & USED_MASK;  // set wins
  end
endmodule

// File: rtl/lsl_irq.sv
module lsl_irq
  import lsl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] latch_i,
  input  logic [REG_W-1:0] bit_en_i,
  input  logic             port_en_i,
  input  logic             glob_en_i,
  output logic             irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= (|(latch_i & bit_en_i)) & port_en_i & glob_en_i;
  end
endmodule

// File: rtl/line_status_latch.sv
module line_status_latch
  import lsl_pkg::*;
#(
  parameter int unsigned PORT_IDX = 0,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned GAIN_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_CHG-1:0]  chg_stat_i,
  input  logic              clk_loss_i,
  input  logic [GAIN_W-1:0] gain_i,
  input  logic              buf_full_i,
  input  logic              buf_empty_i,
  input  logic              buf_slip_i,
  input  logic [REG_W-1:0]  bit_en_i,
  input  logic              port_en_i,
  input  logic              glob_en_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] REG_ADDR = ADDR_W'(PORT_IDX * 32'h80 + 32'h2A);

  logic              armed_q;
  logic [N_CHG-1:0]  chg_ev;
  logic [GAIN_W-1:0] gain_diff;
  logic [REG_W-1:0]  ev;
  logic [REG_W-1:0]  clr_mask;
  logic [REG_W-1:0]  latch_q;
  logic              addr_hit;

  // first edge after reset only loads reference copies
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  lsl_chg_det #(.W(N_CHG)) u_stat_det (
    .clk_i (clk_i), .rst_ni(rst_ni), .arm_i(armed_q),
    .d_i   (chg_stat_i), .chg_o(chg_ev)
  );

  lsl_chg_det #(.W(GAIN_W)) u_gain_det (
    .clk_i (clk_i), .rst_ni(rst_ni), .arm_i(armed_q),
    .d_i   (gain_i), .chg_o(gain_diff)
  );

  lsl_event_map u_map (
    .chg_ev_i  (chg_ev),
    .gain_ev_i (|gain_diff),
    .clk_loss_i(clk_loss_i),
    .full_i    (buf_full_i),
    .empty_i   (buf_empty_i),
    .slip_i    (buf_slip_i),
    .ev_o      (ev)
  );

  assign addr_hit = (reg_addr_i == REG_ADDR);
  assign clr_mask = (reg_wr_i && addr_hit) ? reg_wdata_i : '0;

  lsl_sticky u_sticky (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(ev), .clr_i(clr_mask), .q_o(latch_q)
  );

  lsl_irq u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .latch_i  (latch_q),
    .bit_en_i (bit_en_i),
    .port_en_i(port_en_i),
    .glob_en_i(glob_en_i),
    .irq_o    (irq_o)
  );

  assign reg_rdata_o = addr_hit ? latch_q : '0;
endmodule

// File: rtl/lsl_checker.sv
module lsl_checker
  import lsl_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [REG_W-1:0] reg_rdata_o,
  input logic             irq_o,
  input logic             port_en_i,
  input logic             glob_en_i,
  input logic             clk_loss_i,
  input logic             armed_q,
  input logic [REG_W-1:0] ev,
  input logic [REG_W-1:0] clr_mask,
  input logic [REG_W-1:0] latch_q
);
  assert_unused_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o & ~USED_MASK) == '0);

  assert_irq_gated_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(port_en_i && glob_en_i));

  assert_level_capture_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_loss_i |=> latch_q[POS_CLK]);

  assert_set_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((~latch_q & $past(ev)) == '0));

  assert_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(latch_q) & ~$past(clr_mask) & ~latch_q) == '0));

  assert_no_startup_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q |=> ((latch_q & CHG_MASK) == '0));
endmodule

bind line_status_latch lsl_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_rdata_o(reg_rdata_o),
  .irq_o      (irq_o),
  .port_en_i  (port_en_i),
  .glob_en_i  (glob_en_i),
  .clk_loss_i (clk_loss_i),
  .armed_q    (armed_q),
  .ev         (ev),
  .clr_mask   (clr_mask),
  .latch_q    (latch_q)
);

// File: tb/sim_line_status_latch.sv
`timescale 1ns/1ps
module sim_line_status_latch;
  localparam int unsigned PORT = 5;
  localparam logic [11:0] ADDR = 12'h2AA;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  chg = '0;
  logic        cl = 1'b0;
  logic [7:0]  gain = '0;
  logic        full = 1'b0, empty = 1'b0, slip = 1'b0;
  logic [15:0] ben = '1;
  logic        pen = 1'b1, gen = 1'b1;
  logic [11:0] addr = ADDR;
  logic        wr = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int n_vec = 0, n_bad = 0;
  logic [15:0] m_latch = '0;
  logic        m_irq = 1'b0, m_armed = 1'b0;
  logic [6:0]  m_chg = '0;
  logic [7:0]  m_gain = '0;

  always #10 clk = ~clk;

  line_status_latch #(.PORT_IDX(PORT)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .chg_stat_i(chg), .clk_loss_i(cl), .gain_i(gain),
    .buf_full_i(full), .buf_empty_i(empty), .buf_slip_i(slip), .bit_en_i(ben),
    .port_en_i(pen), .glob_en_i(gen), .reg_addr_i(addr), .reg_wr_i(wr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  function automatic int cpos(int i);
    return (i == 5) ? 9 : (i == 6) ? 10 : i;
  endfunction

  task automatic model_edge();
    logic [15:0] ev = '0, clr;
    if (m_armed) begin
      for (int i = 0; i < 7; i++) if (chg[i] != m_chg[i]) ev[cpos(i)] = 1'b1;
      if (gain != m_gain) ev[5] = 1'b1;
    end
    if (cl) ev[8] = 1'b1;
    if (full || slip) ev[12] = 1'b1;
    if (empty || slip) ev[11] = 1'b1;
    clr = (wr && addr == ADDR) ? wdata : 16'h0;
    m_irq = (|(m_latch & ben)) && pen && gen;
    m_latch = ((m_latch & ~clr) | ev) & 16'h1F3F;
    m_chg = chg; m_gain = gain; m_armed = 1'b1;
  endtask

  task automatic cmp(string tag);
    logic [15:0] er = (addr == ADDR) ? m_latch : 16'h0;
    n_vec++;
    if (rdata !== er || irq !== m_irq) begin
      n_bad++;
      $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b", tag, rdata, irq, er, m_irq);
    end
  endtask

  task automatic step(string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    cmp(tag);
  endtask

  task automatic wclr(logic [15:0] d, string tag);
    wr = 1'b1; wdata = d;
    step(tag);
    wr = 1'b0;
  endtask

  initial begin
    #4000000;
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    chg = 7'h55; gain = 8'h33;           // held through reset (R10)
    repeat (3) @(negedge clk);
    cmp("R1");
    rst_n = 1'b1;
    step("R10"); step("R10"); step("R1");
    // R2: each change input, rise then fall
    for (int i = 0; i < 7; i++) begin
      chg[i] = ~chg[i]; step("R2");
      wclr(16'hFFFF, "R2");
      chg[i] = ~chg[i]; step("R2");
      wclr(16'hFFFF, "R6");
    end
    // R3: level capture survives a clear while high
    cl = 1'b1; step("R3");
    wclr(16'h0100, "R3");
    cl = 1'b0; step("R3");
    wclr(16'h0100, "R3");
    // R4: gain change
    gain = 8'h80; step("R4");
    wclr(16'h0020, "R4");
    // R5: buffer conditions
    full = 1'b1; step("R5"); full = 1'b0;
    empty = 1'b1; step("R5"); empty = 1'b0;
    wclr(16'hFFFF, "R5");
    slip = 1'b1; step("R5"); slip = 1'b0;
    // R6: write-zero keeps bits, set wins over same-edge clear
    wclr(16'h0000, "R6");
    full = 1'b1; wclr(16'h1000, "R6"); full = 1'b0;
    // R7: all-ones write, unused bits stay zero
    wclr(16'hFFFF, "R7");
    cl = 1'b1; step("R7"); cl = 1'b0;
    // R8: other address reads zero and ignores writes
    addr = ADDR ^ 12'h080; step("R8");
    wclr(16'hFFFF, "R8");
    addr = ADDR; step("R8");
    // R9: enable levels
    ben = 16'h0100; step("R9");
    pen = 1'b0; step("R9"); step("R9");
    pen = 1'b1; gen = 1'b0; step("R9"); step("R9");
    gen = 1'b1; ben = 16'h0001; step("R9"); step("R9");
    ben = '1; wclr(16'hFFFF, "R9"); step("R9");
    // random phase
    for (int n = 0; n < 3000; n++) begin
      if ($urandom % 6 == 0) chg = chg ^ 7'(1 << ($urandom % 7));
      cl    = ($urandom % 12 == 0);
      if ($urandom % 8 == 0) gain = 8'($urandom);
      full  = ($urandom % 15 == 0);
      empty = ($urandom % 15 == 0);
      slip  = ($urandom % 25 == 0);
      wr    = ($urandom % 3 == 0);
      wdata = 16'($urandom);
      addr  = ($urandom % 8 == 0) ? 12'($urandom) : ADDR;
      if ($urandom % 16 == 0) ben = 16'($urandom);
      if ($urandom % 16 == 0) pen = 1'($urandom);
      if ($urandom % 16 == 0) gen = 1'($urandom);
      step("RND");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule